// File: doc/BRIEF.md
# Frame-Sequencing SPI Host for a Multichannel Sampling ADC

This block sends one 32-clock SPI frame to a multichannel successive-approximation converter for each accepted request. A frame does two jobs. During the first 16 serial clocks it shifts a 16-bit command out on the host data line, most significant bit first. During the last 16 clocks it collects the converter's 16-bit result. Each request is one of two kinds. It can choose a channel, in which case the command carries the channel number in its upper byte. It can also be a no-operation read, which sends an all-zero command so the next result is clocked out without changing the channel. When the frame ends, the collected word appears on `data` and `data_valid` pulses for one cycle.

The serial clock comes from the system clock. Each half-period lasts exactly `HALF_DIV` system clocks, so the duty cycle is 50%. The serial clock rests low while chip select is high. The converter drives each result bit on a falling edge, so the host samples that bit on the next falling edge, never on the edge that launched it. The result MSB is therefore taken at falling edge 17 and the LSB at falling edge 32. A channel-select frame returns data like any other frame, and software discards results that still belong to the previous channel.

The controller is a five-state machine:
- IDLE: chip select high, clock low. It moves to LEAD when `req` arrives.
- LEAD: chip select is low for one half-period. It moves to HIGH on the divider tick.
- HIGH: the serial clock is high. It moves to LOW on the tick.
- LOW: the serial clock is low. On the tick it returns to HIGH, or it moves to GAP after period 32.
- GAP: chip select is high for `GAP_HALVES` half-periods. It then returns to IDLE.

Top module: `adc_frame_host`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, and both `busy` and `data_valid` are 0.
- R2: A channel-select request sends the command {2'b11, 1'b0, chan[2:0], 2'b00, 8'h00}, which is upper byte 0xC0 + 4·chan. A no-operation request sends 16'h0000. Command bit 15 is sent first and is sampled by the device on falling edge 1.
- R3: While `spi_cs_n` is low a frame has exactly 32 rising and 32 falling `spi_sclk` edges. `spi_mosi` is 0 at falling edges 17 to 32, and `spi_sclk` is never high while `spi_cs_n` is high.
- R4: During a frame, `spi_mosi` changes only together with a rising `spi_sclk` edge or with the falling edge of `spi_cs_n`.
- R5: `data` equals the 16 `spi_miso` values sampled on falling edges 17 to 32, with edge 17 giving bit 15. The value driven after falling edge 16 is taken at edge 17, not at edge 16.
- R6: `data_valid` is a one-cycle pulse in the cycle where `spi_cs_n` returns high. `data` holds its value until the next pulse.
- R7: Every `spi_sclk` half-period inside a frame lasts `HALF_DIV` system clocks. This includes the time from the `spi_cs_n` fall to the first rising edge.
- R8: Between frames `spi_cs_n` stays high for at least `GAP_HALVES`·`HALF_DIV` system clocks, even when `req` is held high.
- R9: A `req` that arrives while `busy` is high is ignored. It starts no frame and does not change the command in flight.
- R10: `busy` is 1 from the cycle after a request is accepted until the gap after the frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a frame; sampled only when idle |
| cmd_is_select | input | 1 | 1: channel-select command, 0: no-operation command |
| chan | input | 3 | Channel number for a select command |
| busy | output | 1 | A frame or its trailing gap is in progress |
| data_valid | output | 1 | One-cycle strobe that a new result is on `data` |
| data | output | 16 | Last captured conversion word |
| spi_sclk | output | 1 | Serial clock; rests low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Command bits to the converter |
| spi_miso | input | 1 | Result bits from the converter |

## Verification
A wrong edge count or state would show at the ports within one frame. A frame would have 31 or 33 clock pulses, or chip select would rise early, and either would also shift the collected word by one bit. Capturing on the launching edge instead of the following one moves every result bit up one place. Patterns such as 0x8001 and 0xA5C3 expose that as a data mismatch in the very frame where it happens. Divider or gap faults change edge spacing by whole system clocks, and the bench measures that spacing on every clock transition. A command register that reloads while busy corrupts the command the device model receives before the current frame completes.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } host_state_t;

    localparam int WORD_W     = 16;
    localparam int FRAME_CLKS = 2 * WORD_W;

    // Channel-select: upper byte 0xC0 + 4*ch, lower byte zero. No-op: all zero.
    function automatic logic [WORD_W-1:0] build_command(input logic sel, input logic [2:0] ch);
        logic [WORD_W-1:0] w;
        w = '0;
        if (sel) begin
            w = {2'b11, 1'b0, ch, 2'b00, 8'h00};
        end
        return w;
    endfunction

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_DIV <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_counted
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

            logic [CW-1:0] half_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    half_cnt <= '0;
                end else if (!run || tick) begin
                    half_cnt <= '0;
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end

            assign tick = run && (half_cnt == LAST);

            AST_HALF_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                half_cnt <= LAST) else $error("half counter out of range"); // R7
            AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> half_cnt == '0) else $error("counter not cleared while stopped"); // R7
        end
    endgenerate

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_host_pkg::*;
#(
    parameter int GAP_HALVES = 2,
    parameter int NUM_CLKS   = FRAME_CLKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output logic run,
    output logic load,
    output logic shift_en,
    output logic capture,
    output logic finish,
    output logic busy,
    output logic sclk,
    output logic cs_n,
    output logic data_valid
);

    localparam int EW = $clog2(NUM_CLKS + 1);
    localparam int GW = $clog2(GAP_HALVES + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(NUM_CLKS);
    localparam logic [EW-1:0] HALF_EDGE = EW'(NUM_CLKS / 2);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_HALVES - 1);

    host_state_t state, state_n;
    logic [EW-1:0] edge_cnt;
    logic [GW-1:0] gap_cnt;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (req)  state_n = ST_LEAD;
            ST_LEAD: if (tick) state_n = ST_HIGH;
            ST_HIGH: if (tick) state_n = ST_LOW;
            ST_LOW:  if (tick) state_n = (edge_cnt == LAST_EDGE) ? ST_GAP : ST_HIGH;
            ST_GAP:  if (tick && gap_cnt == GAP_LAST) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Strobes to the divider and the shift path
    assign run      = (state != ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign load     = (state == ST_IDLE) && req;
    assign shift_en = tick && (state == ST_LOW) && (edge_cnt != LAST_EDGE);
    assign capture  = tick && (state == ST_HIGH) && (edge_cnt > HALF_EDGE);
    assign finish   = tick && (state == ST_LOW) && (edge_cnt == LAST_EDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (load) begin
            edge_cnt <= '0;
        end else if (tick && (state == ST_LEAD || (state == ST_LOW && edge_cnt != LAST_EDGE))) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (state != ST_GAP) begin
            gap_cnt <= '0;
        end else if (tick) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk       <= 1'b0;
            cs_n       <= 1'b1;
            data_valid <= 1'b0;
        end else begin
            sclk       <= (state_n == ST_HIGH);
            cs_n       <= (state_n == ST_IDLE) || (state_n == ST_GAP);
            data_valid <= finish;
        end
    end

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n) else $error("clock high outside frame"); // R3
    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= LAST_EDGE) else $error("edge count overflow"); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid) else $error("valid longer than one cycle"); // R6
    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> data_valid) else $error("frame closed without result"); // R6
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(state) == ST_IDLE) else $error("frame started while busy"); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy) else $error("busy missing after accept"); // R10

endmodule

// File: rtl/adc_shift_path.sv
module adc_shift_path #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cmd_word,
    input  logic         shift_en,
    input  logic         capture,
    input  logic         finish,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] result
);

    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= cmd_word;
        end else if (shift_en) begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
    end

    assign mosi = tx_sr[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (capture) begin
            rx_sr <= {rx_sr[W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (finish) begin
            result <= rx_sr;
        end
    end

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(mosi)) else $error("data line moved off a rising edge"); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(result)) else $error("result changed without strobe"); // R6
    AST_NO_SHIFT_WITH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && capture)) else $error("launch and capture on one edge"); // R5

endmodule

// File: rtl/adc_frame_host.sv
module adc_frame_host
    import adc_host_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int GAP_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              cmd_is_select,
    input  logic [2:0]        chan,
    output logic              busy,
    output logic              data_valid,
    output logic [WORD_W-1:0] data,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic run, tick, load, shift_en, capture, finish;
    logic [WORD_W-1:0] cmd_word;

    assign cmd_word = build_command(cmd_is_select, chan);

    adc_sclk_tick #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_frame_fsm #(
        .GAP_HALVES (GAP_HALVES),
        .NUM_CLKS   (FRAME_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .tick       (tick),
        .run        (run),
        .load       (load),
        .shift_en   (shift_en),
        .capture    (capture),
        .finish     (finish),
        .busy       (busy),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .data_valid (data_valid)
    );

    adc_shift_path #(
        .W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cmd_word (cmd_word),
        .shift_en (shift_en),
        .capture  (capture),
        .finish   (finish),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .result   (data)
    );

endmodule

// File: tb/tb_adc_frame_host.sv
module tb_adc_frame_host;

    localparam int HALF = 3;
    localparam int GAPH = 2;
    localparam int TCLK = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic cmd_is_select = 1'b0;
    logic [2:0] chan = '0;
    logic busy, data_valid, spi_sclk, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;
    logic [15:0] data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_frame_host #(.HALF_DIV(HALF), .GAP_HALVES(GAPH)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .cmd_is_select(cmd_is_select), .chan(chan),
        .busy(busy), .data_valid(data_valid), .data(data),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Converter model: samples command on falling edges 1..16, launches result from edge 16
    logic [15:0] resp_word = '0;
    logic [15:0] cmd_rx = '0;
    int  fall_cnt = 0, rise_cnt = 0, frame_cnt = 0;
    int  half_bad = 0, sdi_bad = 0, tail_bad = 0;
    time cs_fall_t = 0, cs_rise_t = 0, last_edge_t = 0, last_gap = 0;

    always @(negedge spi_cs_n) begin
        fall_cnt = 0; rise_cnt = 0; cmd_rx = '0;
        frame_cnt++;
        cs_fall_t = $time;
        last_edge_t = $time;
        last_gap = $time - cs_rise_t;
    end

    always @(posedge spi_cs_n) cs_rise_t = $time;

    always @(spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            if ($time - last_edge_t != HALF * TCLK) half_bad++;
            last_edge_t = $time;
        end
    end

    always @(posedge spi_sclk) if (spi_cs_n === 1'b0) rise_cnt++;

    always @(negedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            fall_cnt++;
            if (fall_cnt <= 16) cmd_rx = {cmd_rx[14:0], spi_mosi};
            else if (spi_mosi !== 1'b0) tail_bad++;
            if (fall_cnt >= 16 && fall_cnt <= 31) spi_miso <= resp_word[31 - fall_cnt];
        end
    end

    always @(spi_mosi) begin
        time t0;
        t0 = $time;
        #1;
        if (spi_cs_n === 1'b0 && spi_sclk === 1'b0 && t0 != cs_fall_t) sdi_bad++;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input logic sel, input logic [2:0] ch);
        return sel ? {8'hC0 + 8'(ch) * 8'd4, 8'h00} : 16'h0000;
    endfunction

    task automatic send_req(input logic sel, input logic [2:0] ch);
        @(negedge clk);
        req = 1'b1; cmd_is_select = sel; chan = ch;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (data_valid !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(data_valid === 1'b1, "R6", "valid timeout", 32'(n), 32'd5000);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy !== 1'b0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        check(spi_cs_n === 1'b1, "R1", "cs_n after reset", 32'(spi_cs_n), 1);
        check(spi_sclk === 1'b0, "R1", "sclk after reset", 32'(spi_sclk), 0);
        check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(data_valid === 1'b0, "R1", "valid after reset", 32'(data_valid), 0);
    endtask

    task automatic t_frame(input logic sel, input logic [2:0] ch, input logic [15:0] resp);
        resp_word = resp;
        half_bad = 0; sdi_bad = 0; tail_bad = 0;
        send_req(sel, ch);
        check(busy === 1'b1, "R10", "busy after accept", 32'(busy), 1);
        wait_valid();
        check(data === resp, "R5", "captured word", 32'(data), 32'(resp));
        check(cmd_rx === exp_cmd(sel, ch), "R2", "command received", 32'(cmd_rx), 32'(exp_cmd(sel, ch)));
        check(fall_cnt == 32, "R3", "falling edges", 32'(fall_cnt), 32);
        check(rise_cnt == 32, "R3", "rising edges", 32'(rise_cnt), 32);
        check(tail_bad == 0, "R3", "mosi high in result half", 32'(tail_bad), 0);
        check(sdi_bad == 0, "R4", "mosi moved while clock low", 32'(sdi_bad), 0);
        check(half_bad == 0, "R7", "half-period length", 32'(half_bad), 0);
        check(spi_cs_n === 1'b1, "R6", "cs_n high with valid", 32'(spi_cs_n), 1);
        @(negedge clk);
        check(data_valid === 1'b0, "R6", "valid one cycle", 32'(data_valid), 0);
        wait_idle();
        check(data === resp, "R6", "data held", 32'(data), 32'(resp));
    endtask

    task automatic t_busy_ignore();
        int f0 = frame_cnt;
        resp_word = 16'h3C5A;
        send_req(1'b1, 3'd2);
        repeat (10) @(negedge clk);
        check(busy === 1'b1, "R10", "busy mid frame", 32'(busy), 1);
        send_req(1'b1, 3'd5);
        wait_valid();
        check(cmd_rx === exp_cmd(1'b1, 3'd2), "R9", "command not replaced", 32'(cmd_rx), 32'(exp_cmd(1'b1, 3'd2)));
        check(data === 16'h3C5A, "R5", "data in busy test", 32'(data), 32'h3C5A);
        wait_idle();
        repeat (20) @(negedge clk);
        check(frame_cnt == f0 + 1, "R9", "frames started", 32'(frame_cnt - f0), 1);
        check(busy === 1'b0, "R10", "busy cleared after gap", 32'(busy), 0);
    endtask

    task automatic t_back_to_back();
        resp_word = 16'h0F0F;
        @(negedge clk);
        req = 1'b1; cmd_is_select = 1'b0;
        wait_valid();
        check(data === 16'h0F0F, "R5", "first streamed word", 32'(data), 32'h0F0F);
        @(negedge clk);
        resp_word = 16'hF00F;
        wait_valid();
        req = 1'b0;
        check(data === 16'hF00F, "R5", "second streamed word", 32'(data), 32'hF00F);
        check(last_gap >= GAPH * HALF * TCLK, "R8", "cs_n gap ns", 32'(last_gap), 32'(GAPH * HALF * TCLK));
        wait_idle();
    endtask

    initial begin
        #(200000 * TCLK);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(1'b1, 3'd0, 16'h8001);
        t_frame(1'b1, 3'd1, 16'hA5C3);
        t_frame(1'b1, 3'd7, 16'hFFFF);
        t_frame(1'b0, 3'd3, 16'h0000);
        t_frame(1'b0, 3'd0, 16'h1234);
        t_busy_ignore();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule